// File: doc/BRIEF.md
# Multiplexed Asynchronous Bus Target

This block is the device end of a 16-bit asynchronous host bus on which address and data share one set of pins. The host frames every access with an active-low chip select. It presents the address while an active-low address strobe is low, and the block captures that address when the strobe goes high again. After that the pins carry data.

A write places data on the pins and pulses an active-low write strobe. The block stores the data in a bank of sixteen 16-bit words when that strobe rises. A read lowers an active-low output enable. The block looks up the word for the address just captured, raises a wait output while the lookup is still in flight, and then presents the word. While it waits, the outputs show zero. Data from an earlier access never appears.

The pins are split at the pad: `ad_in` carries what is on the pins, and `ad_out` with `ad_drive` feed an external tristate buffer. All bus strobes are brought into the block clock through a two-flop stage.

Top module: `muxbus_target`

## Requirements
- R1: After reset, `ad_drive` and `bus_wait` are 0 and every word of the bank reads back as 0.
- R2: The address on `ad_in` is captured when `bus_adv_n` rises while `bus_cs_n` is low. A strobe seen while `bus_cs_n` is high captures nothing, starts no read and stores no data.
- R3: When `bus_we_n` rises while `bus_cs_n` is low and the captured address is below 16, the value on `ad_in` is stored in word `address[3:0]`.
- R4: A write whose captured address is 16 or above leaves every word of the bank unchanged.
- R5: A read returns the word for the address captured in that same access, even when it directly follows a read of a different word.
- R6: A read of an address of 16 or above returns 0.
- R7: `bus_wait` is 1 no later than 4 clock edges after `bus_adv_n` rises in an access. It falls within RD_LAT+2 edges, and the read data is valid from the cycle it falls.
- R8: `ad_drive` is 1 only while chip select and output enable are both low and `bus_we_n` is high. At all other times it is 0.
- R9: While `ad_drive` is 1 and the read data is not yet ready, including while `bus_wait` is 1, `ad_out` is 0.
- R10: Releasing chip select while a read is pending cancels it: `bus_wait` falls and no data is driven. The next access works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_adv_n | input | 1 | Address strobe, active low; address captured on its rising edge |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write strobe, active low; data stored on its rising edge |
| ad_in | input | 16 | Value on the shared address/data pins |
| ad_out | output | 16 | Read data towards the pins |
| ad_drive | output | 1 | Tristate enable for the shared pins |
| bus_wait | output | 1 | High while the host must stretch the access |

## Verification
Two events can coincide in a single clock: the end of a pending lookup and the release of chip select. Two others can overlap: the output-enable window and the wait window. The bench aborts a read as soon as `bus_wait` is seen. It checks that the wait clears and that nothing is driven. It then reads a different word at once and compares the value against its own model of the bank. On every read, output enable is raised together with the address strobe, so the pins are driven while the lookup is still pending. The bench checks that zero, not the previous word, is shown until the wait drops.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    // Bus strobes after conversion to active-high form
    typedef struct packed {
        logic cs;
        logic adv;
        logic oe;
        logic we;
    } strobes_t;

    // Progress of the read lookup inside one access
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_WAIT  = 2'd1,
        RD_READY = 2'd2
    } rd_phase_t;

    localparam int unsigned STROBE_COUNT = $bits(strobes_t);

endpackage

// File: rtl/mbt_sync.sv
module mbt_sync #(
    parameter int unsigned N      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe[s] <= '1;          // idle level of active-low pins
            end else if (s == 0) begin
                pipe[s] <= d;
            end else begin
                pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/mbt_regbank.sv
module mbt_regbank #(
    parameter int unsigned DW    = 16,
    parameter int unsigned WORDS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int unsigned IW = $clog2(WORDS);

    logic [DW-1:0] mem [WORDS];
    logic          wr_hit;
    logic          rd_hit;

    // WORDS is a power of two: the address hits when all bits above the index are zero
    assign wr_hit = (wr_addr >> IW) == '0;
    assign rd_hit = (rd_addr >> IW) == '0;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (wr_en && wr_hit && (wr_addr[IW-1:0] == IW'(i))) begin
                mem[i] <= wr_data;
            end
        end
    end

    assign rd_data = rd_hit ? mem[rd_addr[IW-1:0]] : '0;
endmodule

// File: rtl/mbt_rdpath.sv
module mbt_rdpath
    import mbt_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned RD_LAT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_act,
    input  logic          cap_fire,
    input  logic [DW-1:0] cap_addr,
    input  logic [DW-1:0] lk_data,
    output logic [DW-1:0] addr_q,
    output logic          bus_wait,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    localparam int unsigned CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

    rd_phase_t     phase;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= RD_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            rd_data <= '0;
        end else if (!cs_act) begin
            phase <= RD_IDLE;
        end else if (cap_fire) begin
            addr_q <= cap_addr;
            cnt    <= CW'(RD_LAT - 1);
            phase  <= RD_WAIT;
        end else if (phase == RD_WAIT) begin
            if (cnt == '0) begin
                rd_data <= lk_data;
                phase   <= RD_READY;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign bus_wait = (phase == RD_WAIT);
    assign rd_valid = (phase == RD_READY);

    // R7: a captured address always opens a wait window
    p_wait_after_capture_r7: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> bus_wait);

    // R5: data becomes ready only after a lookup that waited
    p_ready_after_wait_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(bus_wait));

    // R10: chip-select release cancels any pending or ready read
    p_cs_cancel_r10: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (!bus_wait && !rd_valid));
endmodule

// File: rtl/muxbus_target.sv
module muxbus_target
    import mbt_pkg::*;
#(
    parameter int unsigned DW          = 16,
    parameter int unsigned WORDS       = 16,
    parameter int unsigned RD_LAT      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_cs_n,
    input  logic          bus_adv_n,
    input  logic          bus_oe_n,
    input  logic          bus_we_n,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_drive,
    output logic          bus_wait
);
    logic [STROBE_COUNT-1:0] syn_n;
    strobes_t                act;
    strobes_t                act_d;
    logic                    cap_fire;
    logic                    wr_fire;
    logic [DW-1:0]           addr_q;
    logic [DW-1:0]           lk_data;
    logic [DW-1:0]           rd_data;
    logic                    rd_valid;

    mbt_sync #(.N(STROBE_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n}),
        .q   (syn_n)
    );

    assign act = strobes_t'(~syn_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d <= '0;
        end else begin
            act_d <= act;
        end
    end

    // Deassertion edges, qualified by chip select
    assign cap_fire = act.cs && act_d.adv && !act.adv;
    assign wr_fire  = act.cs && act_d.we  && !act.we;

    mbt_rdpath #(.DW(DW), .RD_LAT(RD_LAT)) u_rdpath (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (act.cs),
        .cap_fire (cap_fire),
        .cap_addr (ad_in),
        .lk_data  (lk_data),
        .addr_q   (addr_q),
        .bus_wait (bus_wait),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    mbt_regbank #(.DW(DW), .WORDS(WORDS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_fire),
        .wr_addr (addr_q),
        .wr_data (ad_in),
        .rd_addr (addr_q),
        .rd_data (lk_data)
    );

    assign ad_drive = act.cs && act.oe && !act.we;
    assign ad_out   = (ad_drive && rd_valid) ? rd_data : '0;

    // R9: pins show zero, never older data, while the host is held off
    p_drive_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (ad_drive && bus_wait) |-> (ad_out == '0));
endmodule

// File: tb/test_muxbus_target.sv
module test_muxbus_target;
    localparam int unsigned DW     = 16;
    localparam int unsigned RD_LAT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_cs_n = 1'b1;
    logic          bus_adv_n = 1'b1;
    logic          bus_oe_n = 1'b1;
    logic          bus_we_n = 1'b1;
    logic [DW-1:0] ad_in = '0;
    logic [DW-1:0] ad_out;
    logic          ad_drive;
    logic          bus_wait;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        string         req;
        logic [DW-1:0] exp;
    } sb_item_t;

    sb_item_t      sb_q[$];
    logic [DW-1:0] obs_val;
    event          obs_ev;
    logic [DW-1:0] model [16];

    always #2 clk = ~clk;   // 250 MHz

    muxbus_target #(.DW(DW), .WORDS(16), .RD_LAT(RD_LAT), .SYNC_STAGES(2)) i_muxbus_target (
        .clk       (clk),
        .rst       (rst),
        .bus_cs_n  (bus_cs_n),
        .bus_adv_n (bus_adv_n),
        .bus_oe_n  (bus_oe_n),
        .bus_we_n  (bus_we_n),
        .ad_in     (ad_in),
        .ad_out    (ad_out),
        .ad_drive  (ad_drive),
        .bus_wait  (bus_wait)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: pops the expected item for each observed read
    initial begin
        forever begin
            @(obs_ev);
            if (sb_q.size() == 0) begin
                check("scoreboard-empty", 32'd1, 32'd0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.req, {16'd0, obs_val}, {16'd0, it.exp});
            end
        end
    end

    function automatic logic [DW-1:0] model_rd(input logic [DW-1:0] a);
        return (a < 16) ? model[a[3:0]] : '0;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [DW-1:0] a, input logic [DW-1:0] d, input bit cs_on);
        @(negedge clk);
        bus_cs_n = !cs_on; bus_adv_n = 1'b0; ad_in = a;
        idle(4);
        bus_adv_n = 1'b1;
        idle(4);
        ad_in = d;
        idle(2);
        bus_we_n = 1'b0;
        idle(4);
        bus_we_n = 1'b1;
        idle(4);
        bus_cs_n = 1'b1;
        idle(4);
        if (cs_on && a < 16) model[a[3:0]] = d;
    endtask

    // Full read: checks wait and zero output, then the scoreboard compares the data
    task automatic bus_read(input logic [DW-1:0] a, input string req);
        int waited;
        sb_q.push_back('{req: req, exp: model_rd(a)});
        @(negedge clk);
        bus_cs_n = 1'b0; bus_adv_n = 1'b0; ad_in = a;
        idle(4);
        bus_adv_n = 1'b1; bus_oe_n = 1'b0;
        idle(4);
        ad_in = 16'hDEAD;
        check("R7 wait raised after address", {31'd0, bus_wait}, 32'd1);
        check("R8 drive during read", {31'd0, ad_drive}, 32'd1);
        check("R9 zero while waiting", {16'd0, ad_out}, 32'd0);
        waited = 0;
        while (bus_wait && waited < 3 * RD_LAT) begin
            idle(1);
            waited++;
        end
        check("R7 wait released in time", {31'd0, bus_wait}, 32'd0);
        obs_val = ad_out;
        -> obs_ev;
        idle(1);
        bus_oe_n = 1'b1; bus_cs_n = 1'b1;
        idle(4);
        check("R8 no drive after access", {31'd0, ad_drive}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        idle(3);
        rst = 1'b0;
        idle(2);
        // R1: reset state
        check("R1 drive after reset", {31'd0, ad_drive}, 32'd0);
        check("R1 wait after reset", {31'd0, bus_wait}, 32'd0);
        bus_read(16'd0, "R1 bank zero word0");
        bus_read(16'd9, "R1 bank zero word9");

        // R3: fill the bank
        for (int i = 0; i < 16; i++) bus_write(16'(i), 16'(i * 16'h1111) ^ 16'h0F0F, 1'b1);
        bus_read(16'd3, "R3 word3");
        bus_read(16'd15, "R3 word15");
        // R5: alternating reads of different words
        bus_read(16'd7, "R5 word7");
        bus_read(16'd0, "R5 word0 after word7");
        bus_read(16'd12, "R5 word12 after word0");
        bus_read(16'd12, "R5 repeat word12");

        // R4: out-of-range write aliasing word 3 must not land
        bus_write(16'h0013, 16'hBEEF, 1'b1);
        bus_read(16'd3, "R4 word3 unchanged");
        bus_write(16'hFFF0, 16'hCAFE, 1'b1);
        bus_read(16'd0, "R4 word0 unchanged");

        // R6: out-of-range reads
        bus_read(16'h0020, "R6 addr 0x20 reads zero");
        bus_read(16'hFFFF, "R6 addr 0xFFFF reads zero");

        // R2: strobes without chip select
        bus_write(16'd5, 16'h1234, 1'b0);
        bus_read(16'd5, "R2 word5 unchanged");
        @(negedge clk);
        bus_adv_n = 1'b0; ad_in = 16'd6;
        idle(4);
        bus_adv_n = 1'b1; bus_oe_n = 1'b0;
        idle(6);
        check("R2 no wait without cs", {31'd0, bus_wait}, 32'd0);
        check("R8 no drive without cs", {31'd0, ad_drive}, 32'd0);
        bus_oe_n = 1'b1;
        idle(2);

        // R8: output enable together with write strobe
        bus_cs_n = 1'b0; bus_oe_n = 1'b0; bus_we_n = 1'b0;
        idle(4);
        check("R8 no drive while writing", {31'd0, ad_drive}, 32'd0);
        bus_cs_n = 1'b1; bus_oe_n = 1'b1; bus_we_n = 1'b1;
        idle(4);

        // R10: abort a read while waiting, then read another word
        bus_cs_n = 1'b0; bus_adv_n = 1'b0; ad_in = 16'd9;
        idle(4);
        bus_adv_n = 1'b1; bus_oe_n = 1'b0;
        idle(4);
        check("R10 wait before abort", {31'd0, bus_wait}, 32'd1);
        bus_cs_n = 1'b1; bus_oe_n = 1'b1;
        idle(4);
        check("R10 wait cleared", {31'd0, bus_wait}, 32'd0);
        check("R10 no drive after abort", {31'd0, ad_drive}, 32'd0);
        bus_read(16'd10, "R10 next read word10");

        idle(4);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule